// File: doc/BRIEF.md
# Logic, Shift and Rotate Unit with Carry

This block applies bitwise logic, shift and rotate operations to a byte or word operand and produces the new value, a write strobe and an updated set of status flags. It is meant to sit beside an integer execution pipeline. The issuing stage presents the destination operand, the source operand, the current flags, an operation code and a count selection, then pulses `start`. The logic operations finish in one pass. Shifts and rotates step one bit position per clock, so that the carry flag always holds the bit that left the operand on the final step.

The count is 1 unless `useCountReg` is high, in which case it comes from `countReg`. A count of zero completes with nothing changed. Byte mode works only on the low half of the operands and clears the upper half of the result. The incoming carry is bit 0 of `flagsIn`. Flags are packed as bit 0 carry (CF), bit 1 even parity of the low byte of the result (PF), bit 2 zero (ZF), bit 3 sign (SF) and bit 4 overflow (OF).

Top module: `logic_shift_unit`

## Requirements
- R1: Op codes 0 (AND), 1 (OR) and 2 (XOR) write the bitwise result of dst and src with writeEn=1. They clear CF and OF and set ZF, SF and PF from the result (for example 0x3785 AND 0x00FF gives 0x0085, and 0x89 OR 0x75 in byte mode gives 0xFD).
- R2: Op code 4 (TEST) reports dst AND src on result with writeEn=0 and sets flags the same way as R1.
- R3: Op code 3 (NOT) writes the ones' complement of dst and returns flagsIn unchanged.
- R4: Op code 5 (shift left) inserts 0 at the LSB and moves the MSB into CF. Op code 6 (logical shift right) inserts 0 at the MSB and moves the LSB into CF. Op code 7 (arithmetic shift right) keeps the MSB and moves the LSB into CF (0x25 gives 0x12 with CF=1). After several steps CF holds only the bit moved out last.
- R5: Op code 8 (rotate left) sends the MSB to both the LSB and CF. Op code 9 (rotate right) sends the LSB to both the MSB and CF.
- R6: Op code 10 (rotate left through carry) moves CF into the LSB and the MSB into CF. Op code 11 (rotate right through carry) moves CF into the MSB and the LSB into CF.
- R7: With useCountReg=0 the shift count is 1 whatever countReg holds. With useCountReg=1 the count is countReg.
- R8: A shift or rotate whose count is 0 returns result equal to dst, writeEn=0 and flags equal to flagsIn.
- R9: For a count of exactly 1, OF is set when the result MSB differs from the dst MSB. For larger counts OF keeps its input value. Shifts (op codes 5-7) set ZF, SF and PF from the result. Rotates (op codes 8-11) leave ZF, SF and PF unchanged.
- R10: With wideMode=0, only bits 7:0 take part: the MSB is bit 7, SF and ZF come from the low byte, and result bits 15:8 are 0.
- R11: done is a one-cycle pulse that appears count+2 clocks after the start cycle for shifts and rotates, and 2 clocks after it for every other op code. While busy is high, start is ignored.
- R12: Op codes 12 to 15 complete with result equal to dst, writeEn=0 and flags equal to flagsIn.
- R13: After reset, done, busy and writeEn are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when not busy) |
| op | input | 4 | Operation code |
| wideMode | input | 1 | 1: 16-bit operands, 0: 8-bit operands |
| useCountReg | input | 1 | 1: count from countReg, 0: count of 1 |
| countReg | input | 8 | Count register value |
| dst | input | 16 | Destination operand |
| src | input | 16 | Source operand |
| flagsIn | input | 5 | Current flags {OF,SF,ZF,PF,CF}; CF is the incoming carry |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| writeEn | output | 1 | Result should be written back (valid with done) |
| result | output | 16 | Operation result (valid with done) |
| flagsOut | output | 5 | Updated flags (valid with done) |

## Verification
The assertions assume that all operand, op-code and count inputs are stable at the clock edge where start is taken, and that their later values do not matter. They also assume that start may arrive at any time, including while the unit is busy. The stimulus drives every input on the falling edge and changes operands only together with a start pulse. It keeps random counts below 20 so that long multi-step runs stay short. One directed case pulses start with different operands in the middle of a run, to show that such a request is dropped.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam logic [3:0] OP_AND  = 4'd0;
  localparam logic [3:0] OP_OR   = 4'd1;
  localparam logic [3:0] OP_XOR  = 4'd2;
  localparam logic [3:0] OP_NOT  = 4'd3;
  localparam logic [3:0] OP_TEST = 4'd4;
  localparam logic [3:0] OP_SHL  = 4'd5;
  localparam logic [3:0] OP_SHR  = 4'd6;
  localparam logic [3:0] OP_SAR  = 4'd7;
  localparam logic [3:0] OP_ROL  = 4'd8;
  localparam logic [3:0] OP_ROR  = 4'd9;
  localparam logic [3:0] OP_RCL  = 4'd10;
  localparam logic [3:0] OP_RCR  = 4'd11;

  localparam int FLAG_W = 5;
  localparam int CF_B = 0;
  localparam int PF_B = 1;
  localparam int ZF_B = 2;
  localparam int SF_B = 3;
  localparam int OF_B = 4;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } lsu_strobe_t;

  function automatic logic isShiftOp(input logic [3:0] o);
    return (o >= OP_SHL) && (o <= OP_RCR);
  endfunction
endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               opIsShift,
  input  logic               useCountReg,
  input  logic [COUNT_W-1:0] countReg,
  output lsu_strobe_t        strobe,
  output logic               busy
);
  typedef enum logic {S_IDLE, S_RUN} state_e;

  state_e             state;
  logic [COUNT_W-1:0] remain;
  logic [COUNT_W-1:0] effCount;

  assign effCount = useCountReg ? countReg : COUNT_W'(1);
  assign busy     = (state == S_RUN);

  always_comb begin
    strobe = '0;
    if (state == S_IDLE) begin
      strobe.load = start;
    end else if (remain != '0) begin
      strobe.step = 1'b1;
    end else begin
      strobe.finish = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      remain <= '0;
    end else if (state == S_IDLE) begin
      if (start) begin
        state  <= S_RUN;
        remain <= opIsShift ? effCount : '0;
      end
    end else if (remain != '0) begin
      remain <= remain - COUNT_W'(1);
    end else begin
      state <= S_IDLE;
    end
  end

  p_count_down_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && remain != '0) |=> (remain == $past(remain) - COUNT_W'(1)));

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && remain != '0) |=> (state == S_RUN));
endmodule

// File: rtl/lsu_datapath.sv
module lsu_datapath
  import lsu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  lsu_strobe_t        strobe,
  input  logic [3:0]         op,
  input  logic               wideMode,
  input  logic               useCountReg,
  input  logic [COUNT_W-1:0] countReg,
  input  logic [DATA_W-1:0]  dst,
  input  logic [DATA_W-1:0]  src,
  input  logic [FLAG_W-1:0]  flagsIn,
  output logic               done,
  output logic               writeEn,
  output logic [DATA_W-1:0]  result,
  output logic [FLAG_W-1:0]  flagsOut
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] FULL_MASK = '1;
  localparam logic [DATA_W-1:0] HALF_MASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  localparam logic [DATA_W-1:0] TOP_WIDE  = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W-1:0] TOP_HALF  = DATA_W'(1) << (HALF_W - 1);

  logic [DATA_W-1:0] accR, srcR;
  logic [3:0]        opR;
  logic              wideR, cfR, msb0R, oneR, zeroR;
  logic [FLAG_W-1:0] flagsR;

  logic [DATA_W-1:0] maskIn, mask, hiBit;
  logic              accTop;
  logic [DATA_W-1:0] shl1, shr1, nextAcc;
  logic              nextCf;

  assign maskIn = wideMode ? FULL_MASK : HALF_MASK;
  assign mask   = wideR ? FULL_MASK : HALF_MASK;
  assign hiBit  = wideR ? TOP_WIDE : TOP_HALF;
  assign accTop = |(accR & hiBit);
  assign shl1   = (accR << 1) & mask;
  assign shr1   = accR >> 1;

  // one bit position per step
  always_comb begin
    nextAcc = accR;
    nextCf  = cfR;
    case (opR)
      OP_SHL: begin nextAcc = shl1;                          nextCf = accTop;  end
      OP_SHR: begin nextAcc = shr1;                          nextCf = accR[0]; end
      OP_SAR: begin nextAcc = shr1 | (accTop ? hiBit : '0);  nextCf = accR[0]; end
      OP_ROL: begin nextAcc = shl1 | DATA_W'(accTop);        nextCf = accTop;  end
      OP_ROR: begin nextAcc = shr1 | (accR[0] ? hiBit : '0); nextCf = accR[0]; end
      OP_RCL: begin nextAcc = shl1 | DATA_W'(cfR);           nextCf = accTop;  end
      OP_RCR: begin nextAcc = shr1 | (cfR ? hiBit : '0);     nextCf = accR[0]; end
      default: ;
    endcase
  end

  logic              isLogic;
  logic [DATA_W-1:0] logicVal, finRes;
  logic              finWe, resTop;
  logic [FLAG_W-1:0] finFlags;

  always_comb begin
    isLogic = (opR == OP_AND) || (opR == OP_OR) || (opR == OP_XOR) || (opR == OP_TEST);
    case (opR)
      OP_AND, OP_TEST: logicVal = accR & srcR;
      OP_OR:           logicVal = accR | srcR;
      OP_XOR:          logicVal = accR ^ srcR;
      OP_NOT:          logicVal = ~accR & mask;
      default:         logicVal = accR;
    endcase
    finRes   = accR;
    finWe    = 1'b0;
    finFlags = flagsR;
    if (isLogic || opR == OP_NOT) begin
      finRes = logicVal;
      finWe  = (opR != OP_TEST);
    end else if (isShiftOp(opR) && !zeroR) begin
      finWe  = 1'b1;
    end
    resTop = |(finRes & hiBit);
    if (isLogic) begin
      finFlags[CF_B] = 1'b0;
      finFlags[OF_B] = 1'b0;
    end else if (isShiftOp(opR) && !zeroR) begin
      finFlags[CF_B] = cfR;
      if (oneR) finFlags[OF_B] = resTop ^ msb0R;
    end
    if (isLogic || ((opR >= OP_SHL) && (opR <= OP_SAR) && !zeroR)) begin
      finFlags[ZF_B] = (finRes == '0);
      finFlags[SF_B] = resTop;
      finFlags[PF_B] = ~^finRes[HALF_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accR     <= '0;
      srcR     <= '0;
      opR      <= '0;
      wideR    <= 1'b0;
      cfR      <= 1'b0;
      msb0R    <= 1'b0;
      oneR     <= 1'b0;
      zeroR    <= 1'b0;
      flagsR   <= '0;
      done     <= 1'b0;
      writeEn  <= 1'b0;
      result   <= '0;
      flagsOut <= '0;
    end else begin
      done    <= strobe.finish;
      writeEn <= strobe.finish && finWe;
      if (strobe.load) begin
        accR   <= dst & maskIn;
        srcR   <= src & maskIn;
        opR    <= op;
        wideR  <= wideMode;
        cfR    <= flagsIn[CF_B];
        msb0R  <= wideMode ? dst[DATA_W-1] : dst[HALF_W-1];
        flagsR <= flagsIn;
        oneR   <= !useCountReg || (countReg == COUNT_W'(1));
        zeroR  <= useCountReg && (countReg == '0);
      end
      if (strobe.step) begin
        accR <= nextAcc;
        cfR  <= nextCf;
      end
      if (strobe.finish) begin
        result   <= finRes;
        flagsOut <= finFlags;
      end
    end
  end

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_test_no_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (done && opR == OP_TEST) |-> !writeEn);

  p_not_keeps_flags_r3: assert property (@(posedge clk) disable iff (!rstN)
    (done && opR == OP_NOT) |-> (flagsOut == flagsR));

  p_logic_clears_r1: assert property (@(posedge clk) disable iff (!rstN)
    (done && (opR == OP_AND || opR == OP_OR || opR == OP_XOR)) |->
      (!flagsOut[CF_B] && !flagsOut[OF_B] && writeEn));

  p_byte_upper_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !wideR) |-> (result[DATA_W-1:HALF_W] == '0));

  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && zeroR && isShiftOp(opR)) |-> (!writeEn && flagsOut == flagsR));

  p_reserved_r12: assert property (@(posedge clk) disable iff (!rstN)
    (done && opR > OP_RCR) |-> (!writeEn && flagsOut == flagsR));
endmodule

// File: rtl/logic_shift_unit.sv
module logic_shift_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [3:0]         op,
  input  logic               wideMode,
  input  logic               useCountReg,
  input  logic [COUNT_W-1:0] countReg,
  input  logic [DATA_W-1:0]  dst,
  input  logic [DATA_W-1:0]  src,
  input  logic [FLAG_W-1:0]  flagsIn,
  output logic               busy,
  output logic               done,
  output logic               writeEn,
  output logic [DATA_W-1:0]  result,
  output logic [FLAG_W-1:0]  flagsOut
);
  lsu_strobe_t strobe;
  logic        opIsShift;

  assign opIsShift = isShiftOp(op);

  lsu_ctrl #(.COUNT_W(COUNT_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .opIsShift   (opIsShift),
    .useCountReg (useCountReg),
    .countReg    (countReg),
    .strobe      (strobe),
    .busy        (busy)
  );

  lsu_datapath #(.DATA_W(DATA_W), .COUNT_W(COUNT_W)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .op          (op),
    .wideMode    (wideMode),
    .useCountReg (useCountReg),
    .countReg    (countReg),
    .dst         (dst),
    .src         (src),
    .flagsIn     (flagsIn),
    .done        (done),
    .writeEn     (writeEn),
    .result      (result),
    .flagsOut    (flagsOut)
  );

  p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: tb/sim_logic_shift_unit.sv
`timescale 1ns/1ps
module sim_logic_shift_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic        wideMode = 1'b1;
  logic        useCountReg = 1'b0;
  logic [7:0]  countReg = '0;
  logic [15:0] dst = '0, src = '0;
  logic [4:0]  flagsIn = '0;
  logic        busy, done, writeEn;
  logic [15:0] result;
  logic [4:0]  flagsOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  logic_shift_unit u0 (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .wideMode(wideMode),
    .useCountReg(useCountReg), .countReg(countReg), .dst(dst), .src(src),
    .flagsIn(flagsIn), .busy(busy), .done(done), .writeEn(writeEn),
    .result(result), .flagsOut(flagsOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // returns {we, flags[4:0], result[15:0]}
  function automatic logic [21:0] model(input logic [3:0] o, input logic w,
      input logic uc, input logic [7:0] cr, input logic [15:0] d,
      input logic [15:0] s, input logic [4:0] fl);
    logic [15:0] m, v, sv, r;
    logic [4:0] f;
    logic c, hi, lo, we;
    int hb, n;
    m = w ? 16'hFFFF : 16'h00FF;
    hb = w ? 15 : 7;
    v = d & m; sv = s & m; c = fl[0]; f = fl; we = 1'b0; r = v;
    n = uc ? int'(cr) : 1;
    if (o <= 4) begin
      case (o)
        0, 4: r = v & sv;
        1: r = v | sv;
        2: r = v ^ sv;
        default: r = ~v & m;
      endcase
      we = (o != 4);
      if (o != 3) begin
        f[0] = 0; f[4] = 0;
        f[2] = (r == 0); f[3] = r[hb]; f[1] = ~^r[7:0];
      end
    end else if (o <= 11 && n != 0) begin
      for (int i = 0; i < n; i++) begin
        hi = v[hb]; lo = v[0];
        case (o)
          5: begin v = (v << 1) & m; c = hi; end
          6: begin v = v >> 1; c = lo; end
          7: begin v = v >> 1; v[hb] = hi; c = lo; end
          8: begin v = ((v << 1) & m) | 16'(hi); c = hi; end
          9: begin v = v >> 1; v[hb] = lo; c = lo; end
          10: begin v = ((v << 1) & m) | 16'(c); c = hi; end
          default: begin v = v >> 1; v[hb] = c; c = lo; end
        endcase
      end
      r = v; we = 1'b1; f[0] = c;
      if (n == 1) f[4] = r[hb] ^ d[hb];
      if (o <= 7) begin
        f[2] = (r == 0); f[3] = r[hb]; f[1] = ~^r[7:0];
      end
    end
    return {we, f, r};
  endfunction

  function automatic string tagOf(input logic [3:0] o);
    case (o)
      0, 1, 2: return "R1";
      3: return "R3";
      4: return "R2";
      5, 6, 7: return "R4";
      8, 9: return "R5";
      10, 11: return "R6";
      default: return "R12";
    endcase
  endfunction

  task automatic runOp(input logic [3:0] o, input logic w, input logic uc,
      input logic [7:0] cr, input logic [15:0] d, input logic [15:0] s,
      input logic [4:0] fl, input string tag);
    logic [21:0] e;
    int lat, n;
    e = model(o, w, uc, cr, d, s, fl);
    n = (o >= 5 && o <= 11) ? (uc ? int'(cr) : 1) : 0;
    @(negedge clk);
    op = o; wideMode = w; useCountReg = uc; countReg = cr;
    dst = d; src = s; flagsIn = fl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    chk({tag, " R11 latency"}, 32'(lat), 32'(n + 2));
    chk({tag, " result"}, 32'(result), 32'(e[15:0]));
    chk({tag, " writeEn"}, 32'(writeEn), 32'(e[21]));
    chk({tag, (o >= 5 && o <= 11) ? " R9 flags" : " flags"}, 32'(flagsOut), 32'(e[20:16]));
    if (!w) chk("R10 upper byte", 32'(result[15:8]), 32'h0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R13 done", 32'(done), 32'h0);
    chk("R13 busy", 32'(busy), 32'h0);
    chk("R13 writeEn", 32'(writeEn), 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // directed corners
    runOp(0, 1, 0, 0, 16'h3785, 16'h00FF, 5'h1F, "R1 and");
    chk("R1 and value", 32'(result), 32'h0085);
    runOp(1, 0, 0, 0, 16'h0089, 16'h0075, 5'h00, "R1 or");
    chk("R1 or value", 32'(result), 32'h00FD);
    runOp(4, 1, 0, 0, 16'hF0F0, 16'h0F0F, 5'h01, "R2 test");
    chk("R2 test flags", 32'(flagsOut), 32'h06);
    runOp(3, 1, 0, 0, 16'h1234, 16'h0, 5'h15, "R3 not");
    runOp(7, 0, 0, 0, 16'h0025, 16'h0, 5'h00, "R4 sar");
    chk("R4 sar value", 32'({flagsOut[0], result}), 32'h10012);
    runOp(6, 0, 0, 0, 16'h00B2, 16'h0, 5'h01, "R4 shr");
    chk("R4 shr value", 32'({flagsOut[0], result}), 32'h00059);
    runOp(5, 1, 1, 8'd3, 16'hA001, 16'h0, 5'h00, "R4 shl3");
    runOp(9, 1, 1, 8'd4, 16'h1234, 16'h0, 5'h00, "R5 ror4");
    chk("R5 nibble", 32'(result), 32'h4123);
    runOp(8, 0, 1, 8'd1, 16'h0081, 16'h0, 5'h00, "R5 rol1");
    runOp(10, 0, 1, 8'd9, 16'h00C3, 16'h0, 5'h01, "R6 rcl9");
    chk("R6 rcl9 value", 32'(result), 32'h00C3);
    runOp(11, 1, 1, 8'd1, 16'h0001, 16'h0, 5'h01, "R6 rcr1");
    runOp(5, 1, 0, 8'd7, 16'h4000, 16'h0, 5'h00, "R7 implicit one");
    chk("R7 one step", 32'(result), 32'h8000);
    runOp(6, 1, 1, 8'd0, 16'hBEEF, 16'h0, 5'h0A, "R8 zero count");
    runOp(8, 1, 1, 8'd0, 16'h8001, 16'h0, 5'h15, "R8 zero rotate");
    runOp(13, 1, 0, 0, 16'h5555, 16'h0, 5'h0C, "R12 reserved");

    // start while busy is dropped
    @(negedge clk);
    op = 4'd5; wideMode = 1; useCountReg = 1; countReg = 8'd10;
    dst = 16'h0001; src = 0; flagsIn = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    op = 4'd1; dst = 16'hFFFF; src = 16'hFFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk("R11 busy start ignored", 32'(result), 32'h0400);
    begin
      int extra = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R11 no extra done", 32'(extra), 32'h0);
    end

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [3:0] o;
      logic [7:0] c;
      o = 4'($urandom % 16);
      c = 8'($urandom % 20);
      runOp(o, 1'($urandom), 1'($urandom), c, 16'($urandom), 16'($urandom),
            5'($urandom), tagOf(o));
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule